// File: doc/BRIEF.md
# Multi-Mode Output Compare Channel

This block is one output compare channel. It watches the count of one of two free-running timers, which are outside the block. It drives an output pin according to a 3-bit behaviour field. The behaviours are: off, set on match, clear on match, toggle on match, single pulse, repeated pulses, and pulse-width modulation with or without a fault shutdown. The channel holds a primary compare value and a secondary compare value. In the PWM behaviours the primary value is the duty threshold, and it is taken into use only at the period boundary of the selected timer.

Software reaches the channel through a small word-wide register port. That port holds a control word, the primary value and the secondary value. Each compare event also raises a one-cycle interrupt pulse. An idle request input can freeze the channel when the control word asks for this. A fault input shuts the pin down in the fault-aware PWM behaviour and sets a sticky status flag that software cannot write.

Top module: `oc_channel`

## Requirements
- R1: After reset the pin is low, the interrupt is low and all registers read 0. With behaviour 000 the pin stays low and no interrupt is raised.
- R2: When the control word is written with behaviour 001, the pin goes low at the next edge. A primary match then drives it high and pulses the interrupt.
- R3: When the control word is written with behaviour 010, the pin goes high at the next edge. A primary match then drives it low and pulses the interrupt.
- R4: With behaviour 011, each primary match inverts the pin and pulses the interrupt.
- R5: Behaviour 100 starts low. The pin rises on a primary match, then falls on a secondary match with an interrupt. After that it stays low until the control word is written again.
- R6: Behaviour 101 starts low. It rises on every primary match and falls with an interrupt on every secondary match, without limit.
- R7: Behaviours 110 and 111 drive the pin high and pulse the interrupt on the selected timer's period strobe. The pin goes low when the count equals the active duty value. The strobe of the timer that is not selected has no effect.
- R8: Control bit 3 selects the timebase: 0 selects timer 0 (tb0_*) and 1 selects timer 1 (tb1_*). The count of the timer that is not selected has no effect.
- R9: In behaviour 111 an asserted fault input forces the pin low and sets the fault flag (control bit 4). While the flag is set, the pin stays low and no interrupts occur. Only a write of the control word clears the flag, and the value written to bit 4 is ignored.
- R10: In behaviour 110 the fault input has no effect, and the fault flag stays 0.
- R11: In PWM a new primary value becomes the active duty value only at the next period strobe.
- R12: With control bit 13 set and the idle request high, the pin, the interrupt and the pulse state are frozen. With bit 13 clear, the idle request is ignored.
- R13: Register select 0 is the control word. Its layout is: bit 13 stop-in-idle, bit 4 fault flag (read-only), bit 3 timer select, bits 2:0 behaviour. All other bits read 0. Select 1 is the primary value and select 2 is the secondary value. Select 3 reads 0. A write takes effect at the next edge, and the pin is initialised in that same cycle with no match being evaluated.
- R14: Every compare event gives exactly one cycle of interrupt.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tb0_cnt | input | CW | Count of timer 0 |
| tb0_prd | input | 1 | Period strobe of timer 0 |
| tb1_cnt | input | CW | Count of timer 1 |
| tb1_prd | input | 1 | Period strobe of timer 1 |
| fault_in | input | 1 | Fault request, active high |
| idle_req | input | 1 | Idle request, active high |
| reg_wr | input | 1 | Register write strobe |
| reg_sel | input | 2 | Register select |
| reg_wdata | input | 16 | Register write data |
| reg_rdata | output | 16 | Read data of the selected register |
| oc_pin | output | 1 | Output pin level |
| oc_irq | output | 1 | Compare event pulse |

## Verification
The hardest state to reach is the sticky fault: it needs the fault-aware PWM behaviour, a running period, an asserted fault, and then a later period strobe that must not raise the pin again. The bench builds this sequence on purpose. It then rewrites the control word with bit 4 set and checks that the flag is clear after the write, not set. The buffered duty value needs a second difficult sequence: the primary value changes mid-period, and the old threshold must still cut the current period while the new one applies only after the next strobe.

// File: rtl/oc_pkg.sv
package oc_pkg;
   localparam int REG_W      = 16;
   localparam int STOP_BIT   = 13;
   localparam int FLT_BIT    = 4;
   localparam int TSEL_BIT   = 3;

   typedef enum logic [2:0] {
      OCM_OFF  = 3'd0,
      OCM_SET  = 3'd1,
      OCM_CLR  = 3'd2,
      OCM_TGL  = 3'd3,
      OCM_ONE  = 3'd4,
      OCM_CONT = 3'd5,
      OCM_PWM  = 3'd6,
      OCM_PWMF = 3'd7
   } ocm_e;

   typedef enum logic [1:0] {
      SEL_CTRL = 2'd0,
      SEL_PRI  = 2'd1,
      SEL_SEC  = 2'd2,
      SEL_NONE = 2'd3
   } regsel_e;
endpackage

// File: rtl/oc_regs.sv
module oc_regs
   import oc_pkg::*;
#(
   parameter int CW = 16
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 wr,
   input  logic [1:0]           sel,
   input  logic [REG_W-1:0]     wdata,
   input  logic                 flt,
   output ocm_e                 mode,
   output logic                 tsel,
   output logic                 stop_idle,
   output logic [CW-1:0]        pri,
   output logic [CW-1:0]        sec,
   output logic                 ctrl_wr,
   output ocm_e                 new_mode,
   output logic [REG_W-1:0]     rdata
);
   regsel_e sel_e;
   assign sel_e    = regsel_e'(sel);
   assign ctrl_wr  = wr && (sel_e == SEL_CTRL);
   assign new_mode = ocm_e'(wdata[2:0]);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         mode      <= OCM_OFF;
         tsel      <= 1'b0;
         stop_idle <= 1'b0;
         pri       <= '0;
         sec       <= '0;
      end else if (wr) begin
         case (sel_e)
            SEL_CTRL: begin
               mode      <= new_mode;
               tsel      <= wdata[TSEL_BIT];
               stop_idle <= wdata[STOP_BIT];
            end
            SEL_PRI:  pri <= wdata[CW-1:0];
            SEL_SEC:  sec <= wdata[CW-1:0];
            default:  ;
         endcase
      end
   end

   always_comb begin
      rdata = '0;
      case (sel_e)
         SEL_CTRL: begin
            rdata[STOP_BIT] = stop_idle;
            rdata[FLT_BIT]  = flt;
            rdata[TSEL_BIT] = tsel;
            rdata[2:0]      = mode;
         end
         SEL_PRI:  rdata = REG_W'(pri);
         SEL_SEC:  rdata = REG_W'(sec);
         default:  rdata = '0;
      endcase
   end
endmodule

// File: rtl/oc_tbsel.sv
module oc_tbsel #(
   parameter int CW = 16
) (
   input  logic          tsel,
   input  logic [CW-1:0] cnt0,
   input  logic          prd0,
   input  logic [CW-1:0] cnt1,
   input  logic          prd1,
   output logic [CW-1:0] cnt,
   output logic          prd
);
   assign cnt = tsel ? cnt1 : cnt0;
   assign prd = tsel ? prd1 : prd0;
endmodule

// File: rtl/oc_engine.sv
module oc_engine
   import oc_pkg::*;
#(
   parameter int CW = 16
) (
   input  logic          clk,
   input  logic          rst_n,
   input  ocm_e          mode,
   input  logic          ctrl_wr,
   input  ocm_e          new_mode,
   input  logic          halt,
   input  logic          fault_in,
   input  logic [CW-1:0] cnt,
   input  logic          prd,
   input  logic [CW-1:0] pri,
   input  logic [CW-1:0] sec,
   output logic          pin,
   output logic          irq,
   output logic          flt
);
   logic          done_q;
   logic [CW-1:0] duty_q;
   logic          hit_p, hit_s, hit_d;

   assign hit_p = (cnt == pri);
   assign hit_s = (cnt == sec);
   assign hit_d = (cnt == duty_q);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         pin    <= 1'b0;
         irq    <= 1'b0;
         flt    <= 1'b0;
         done_q <= 1'b0;
         duty_q <= '0;
      end else begin
         irq <= 1'b0;
         if (ctrl_wr) begin
            pin    <= (new_mode == OCM_CLR);
            flt    <= 1'b0;
            done_q <= 1'b0;
         end else if (mode == OCM_PWMF && fault_in) begin
            flt <= 1'b1;
            pin <= 1'b0;
         end else if (flt) begin
            pin <= 1'b0;
         end else if (!halt) begin
            case (mode)
               OCM_OFF: pin <= 1'b0;
               OCM_SET: if (hit_p) begin pin <= 1'b1; irq <= 1'b1; end
               OCM_CLR: if (hit_p) begin pin <= 1'b0; irq <= 1'b1; end
               OCM_TGL: if (hit_p) begin pin <= ~pin; irq <= 1'b1; end
               OCM_ONE, OCM_CONT: begin
                  if (!pin && !done_q && hit_p) begin
                     pin <= 1'b1;
                  end else if (pin && hit_s) begin
                     pin <= 1'b0;
                     irq <= 1'b1;
                     if (mode == OCM_ONE) done_q <= 1'b1;
                  end
               end
               default: begin
                  if (prd) begin
                     pin    <= 1'b1;
                     irq    <= 1'b1;
                     duty_q <= pri;
                  end else if (hit_d) begin
                     pin <= 1'b0;
                  end
               end
            endcase
         end
      end
   end
endmodule

// File: rtl/oc_channel.sv
module oc_channel
   import oc_pkg::*;
#(
   parameter int CW = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [CW-1:0]    tb0_cnt,
   input  logic             tb0_prd,
   input  logic [CW-1:0]    tb1_cnt,
   input  logic             tb1_prd,
   input  logic             fault_in,
   input  logic             idle_req,
   input  logic             reg_wr,
   input  logic [1:0]       reg_sel,
   input  logic [15:0]      reg_wdata,
   output logic [15:0]      reg_rdata,
   output logic             oc_pin,
   output logic             oc_irq
);
   if (CW < 2 || CW > REG_W) begin : g_bad_cw
      $error("oc_channel: CW must lie in 2..16");
   end

   ocm_e          mode_q, new_mode;
   logic          tsel_q, stop_q, ctrl_wr, flt_q, halt;
   logic [CW-1:0] pri_q, sec_q, cnt_sel;
   logic          prd_sel;

   assign halt = stop_q && idle_req;

   oc_regs #(.CW(CW)) u_regs (
      .clk(clk), .rst_n(rst_n), .wr(reg_wr), .sel(reg_sel), .wdata(reg_wdata),
      .flt(flt_q), .mode(mode_q), .tsel(tsel_q), .stop_idle(stop_q),
      .pri(pri_q), .sec(sec_q), .ctrl_wr(ctrl_wr), .new_mode(new_mode),
      .rdata(reg_rdata)
   );

   oc_tbsel #(.CW(CW)) u_tbsel (
      .tsel(tsel_q), .cnt0(tb0_cnt), .prd0(tb0_prd),
      .cnt1(tb1_cnt), .prd1(tb1_prd), .cnt(cnt_sel), .prd(prd_sel)
   );

   oc_engine #(.CW(CW)) u_eng (
      .clk(clk), .rst_n(rst_n), .mode(mode_q), .ctrl_wr(ctrl_wr),
      .new_mode(new_mode), .halt(halt), .fault_in(fault_in),
      .cnt(cnt_sel), .prd(prd_sel), .pri(pri_q), .sec(sec_q),
      .pin(oc_pin), .irq(oc_irq), .flt(flt_q)
   );
endmodule

// File: rtl/oc_checker.sv
module oc_checker (
   input logic        clk,
   input logic        rst_n,
   input logic [2:0]  mode,
   input logic        stop,
   input logic        flt,
   input logic        ctrl_wr,
   input logic        fault_in,
   input logic        idle_req,
   input logic        reg_wr,
   input logic [1:0]  reg_sel,
   input logic [15:0] reg_wdata,
   input logic        oc_pin,
   input logic        oc_irq
);
   a_r1_off_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      (mode == 3'd0) |-> (!oc_pin && !oc_irq));

   a_r3_init_high: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_wr && reg_sel == 2'd0 && reg_wdata[2:0] == 3'd2) |=> oc_pin);

   a_r9_fault_low: assert property (@(posedge clk) disable iff (!rst_n)
      flt |-> (!oc_pin && !oc_irq));

   a_r10_fault_source: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(flt) |-> $past(mode == 3'd7 && fault_in));

   a_r12_idle_freeze: assert property (@(posedge clk) disable iff (!rst_n)
      (stop && idle_req && !ctrl_wr && !(mode == 3'd7 && fault_in))
      |=> ($stable(oc_pin) && !oc_irq));
endmodule

bind oc_channel oc_checker u_chk (
   .clk(clk), .rst_n(rst_n), .mode(mode_q), .stop(stop_q), .flt(flt_q),
   .ctrl_wr(ctrl_wr), .fault_in(fault_in), .idle_req(idle_req),
   .reg_wr(reg_wr), .reg_sel(reg_sel), .reg_wdata(reg_wdata),
   .oc_pin(oc_pin), .oc_irq(oc_irq)
);

// File: tb/sim_oc_channel.sv
`timescale 1ns/1ps
module sim_oc_channel;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [15:0] tb0_cnt = '0, tb1_cnt = '0;
   logic        tb0_prd = 1'b0, tb1_prd = 1'b0;
   logic        fault_in = 1'b0, idle_req = 1'b0;
   logic        reg_wr = 1'b0;
   logic [1:0]  reg_sel = '0;
   logic [15:0] reg_wdata = '0;
   logic [15:0] reg_rdata;
   logic        oc_pin, oc_irq;
   int          total = 0, bad = 0;
   bit          ended = 0;

   always #10 clk = ~clk;

   oc_channel u0 (.*);

   // fields: cfg, tsel, mode, prd0, cnt0, prd1, cnt1, pin, irq
   localparam int NV = 25;
   localparam logic [24:0] VEC [NV] = '{
      {1'b1,1'b0,3'd1,1'b0,8'd0 ,1'b0,8'd0 ,1'b0,1'b0}, // R2 init low
      {1'b0,1'b0,3'd1,1'b0,8'd10,1'b0,8'd0 ,1'b1,1'b1}, // R2 set, R14
      {1'b0,1'b0,3'd1,1'b0,8'd11,1'b0,8'd0 ,1'b1,1'b0}, // R14 one cycle
      {1'b1,1'b0,3'd2,1'b0,8'd0 ,1'b0,8'd0 ,1'b1,1'b0}, // R3 init high
      {1'b0,1'b0,3'd2,1'b0,8'd10,1'b0,8'd0 ,1'b0,1'b1}, // R3 clear
      {1'b1,1'b0,3'd3,1'b0,8'd0 ,1'b0,8'd0 ,1'b0,1'b0}, // R4 init
      {1'b0,1'b0,3'd3,1'b0,8'd10,1'b0,8'd0 ,1'b1,1'b1}, // R4 toggle
      {1'b0,1'b0,3'd3,1'b0,8'd11,1'b0,8'd0 ,1'b1,1'b0}, // R4 hold
      {1'b0,1'b0,3'd3,1'b0,8'd10,1'b0,8'd0 ,1'b0,1'b1}, // R4 toggle back
      {1'b1,1'b0,3'd4,1'b0,8'd0 ,1'b0,8'd0 ,1'b0,1'b0}, // R5 init
      {1'b0,1'b0,3'd4,1'b0,8'd10,1'b0,8'd0 ,1'b1,1'b0}, // R5 rise
      {1'b0,1'b0,3'd4,1'b0,8'd20,1'b0,8'd0 ,1'b0,1'b1}, // R5 fall
      {1'b0,1'b0,3'd4,1'b0,8'd10,1'b0,8'd0 ,1'b0,1'b0}, // R5 no second pulse
      {1'b1,1'b0,3'd5,1'b0,8'd0 ,1'b0,8'd0 ,1'b0,1'b0}, // R6 init
      {1'b0,1'b0,3'd5,1'b0,8'd10,1'b0,8'd0 ,1'b1,1'b0}, // R6 rise
      {1'b0,1'b0,3'd5,1'b0,8'd20,1'b0,8'd0 ,1'b0,1'b1}, // R6 fall
      {1'b0,1'b0,3'd5,1'b0,8'd10,1'b0,8'd0 ,1'b1,1'b0}, // R6 rise again
      {1'b1,1'b1,3'd3,1'b0,8'd10,1'b0,8'd0 ,1'b0,1'b0}, // R8 select timer 1, R13 no match on write
      {1'b0,1'b1,3'd3,1'b0,8'd10,1'b0,8'd5 ,1'b0,1'b0}, // R8 timer 0 ignored
      {1'b0,1'b1,3'd3,1'b0,8'd0 ,1'b0,8'd10,1'b1,1'b1}, // R8 timer 1 match
      {1'b1,1'b0,3'd6,1'b0,8'd0 ,1'b0,8'd0 ,1'b0,1'b0}, // R7 init
      {1'b0,1'b0,3'd6,1'b1,8'd50,1'b0,8'd0 ,1'b1,1'b1}, // R7 period
      {1'b0,1'b0,3'd6,1'b0,8'd5 ,1'b0,8'd0 ,1'b1,1'b0}, // R7 below duty
      {1'b0,1'b0,3'd6,1'b0,8'd10,1'b0,8'd0 ,1'b0,1'b0}, // R7 duty reached
      {1'b0,1'b0,3'd6,1'b0,8'd3 ,1'b1,8'd0 ,1'b0,1'b0}  // R7 other strobe ignored
   };

   task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   // called at a falling edge; applies one cycle and returns at the next falling edge
   task automatic cyc(input logic [15:0] c0, input logic p0, input logic [15:0] c1, input logic p1);
      tb0_cnt = c0; tb0_prd = p0; tb1_cnt = c1; tb1_prd = p1;
      @(posedge clk); @(negedge clk);
      reg_wr = 1'b0;
   endtask

   task automatic wreg(input logic [1:0] s, input logic [15:0] d);
      reg_wr = 1'b1; reg_sel = s; reg_wdata = d;
      cyc(16'd0, 1'b0, 16'd0, 1'b0);
   endtask

   task automatic rreg(input logic [1:0] s, output logic [15:0] d);
      reg_sel = s; #1; d = reg_rdata;
   endtask

   task automatic pins(input string tag, input logic p, input logic i);
      chk({tag, " pin"}, {15'd0, oc_pin}, {15'd0, p});
      chk({tag, " irq"}, {15'd0, oc_irq}, {15'd0, i});
   endtask

   initial begin : watchdog
      repeat (20000) @(posedge clk);
      if (!ended) begin
         ended = 1;
         total++; bad++;
         $display("FAIL watchdog actual=hung expected=done");
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin : main
      logic [15:0] rd;
      repeat (3) @(negedge clk);
      // R1 reset state
      pins("R1 reset", 1'b0, 1'b0);
      rreg(2'd0, rd); chk("R1 reset ctrl", rd, 16'h0000);
      rreg(2'd1, rd); chk("R1 reset primary", rd, 16'h0000);
      rst_n = 1'b1;
      @(negedge clk);
      wreg(2'd1, 16'd10);
      wreg(2'd2, 16'd20);

      for (int k = 0; k < NV; k++) begin
         logic [24:0] v;
         v = VEC[k];
         if (v[24]) begin
            reg_wr = 1'b1; reg_sel = 2'd0;
            reg_wdata = {12'd0, v[23], v[22:20]};
         end
         cyc({8'd0, v[18:11]}, v[19], {8'd0, v[9:2]}, v[10]);
         pins($sformatf("vector %0d", k), v[1], v[0]);
      end

      // R9 fault latch in mode 111
      wreg(2'd0, 16'h0007);
      pins("R9 init", 1'b0, 1'b0);
      cyc(16'd50, 1'b1, 16'd0, 1'b0);
      pins("R9 period", 1'b1, 1'b1);
      fault_in = 1'b1;
      cyc(16'd5, 1'b0, 16'd0, 1'b0);
      pins("R9 fault forces low", 1'b0, 1'b0);
      rreg(2'd0, rd); chk("R9 flag set", rd, 16'h0017);
      fault_in = 1'b0;
      cyc(16'd50, 1'b1, 16'd0, 1'b0);
      pins("R9 sticky after strobe", 1'b0, 1'b0);
      wreg(2'd0, 16'h0016);
      rreg(2'd0, rd); chk("R9 flag cleared by rewrite, bit4 ignored", rd, 16'h0006);
      // R10 mode 110 ignores fault
      fault_in = 1'b1;
      cyc(16'd50, 1'b1, 16'd0, 1'b0);
      pins("R10 fault ignored", 1'b1, 1'b1);
      rreg(2'd0, rd); chk("R10 flag stays 0", rd, 16'h0006);
      fault_in = 1'b0;

      // R11 duty buffered until period
      cyc(16'd0, 1'b0, 16'd0, 1'b0);
      wreg(2'd1, 16'd30);
      cyc(16'd10, 1'b0, 16'd0, 1'b0);
      pins("R11 old duty used", 1'b0, 1'b0);
      cyc(16'd50, 1'b1, 16'd0, 1'b0);
      pins("R11 period", 1'b1, 1'b1);
      cyc(16'd10, 1'b0, 16'd0, 1'b0);
      pins("R11 old threshold gone", 1'b1, 1'b0);
      cyc(16'd30, 1'b0, 16'd0, 1'b0);
      pins("R11 new duty", 1'b0, 1'b0);

      // R12 stop in idle
      wreg(2'd1, 16'd10);
      wreg(2'd0, 16'h2003);
      idle_req = 1'b1;
      cyc(16'd10, 1'b0, 16'd0, 1'b0);
      pins("R12 halted", 1'b0, 1'b0);
      idle_req = 1'b0;
      cyc(16'd10, 1'b0, 16'd0, 1'b0);
      pins("R12 resumed", 1'b1, 1'b1);
      wreg(2'd0, 16'h0003);
      idle_req = 1'b1;
      cyc(16'd10, 1'b0, 16'd0, 1'b0);
      pins("R12 runs in idle", 1'b1, 1'b1);
      idle_req = 1'b0;

      // R13 register layout
      wreg(2'd0, 16'hFFFF);
      rreg(2'd0, rd); chk("R13 ctrl unused bits", rd, 16'h200F);
      wreg(2'd2, 16'h1234);
      rreg(2'd2, rd); chk("R13 secondary", rd, 16'h1234);
      rreg(2'd1, rd); chk("R13 primary", rd, 16'h000A);
      rreg(2'd3, rd); chk("R13 select 3", rd, 16'h0000);

      // R1 disabled mode
      wreg(2'd0, 16'h0000);
      cyc(16'd10, 1'b1, 16'd10, 1'b1);
      pins("R1 disabled", 1'b0, 1'b0);

      if (!ended) begin
         ended = 1;
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end
endmodule